// File: doc/BRIEF.md
# Countdown Timer and Interrupt Controller

This block pairs a reloading countdown timer with the flag and interrupt logic of a real-time clock. It runs from a clock-enable input that pulses at 32768 Hz. A prescaler derives one of four source rates from it, and each source tick decrements a counter that starts at the loaded count n. When the counter expires, the timer flag is set and the counter reloads from n, so the timer runs periodically. An alarm-match strobe from a neighbouring comparator sets a second sticky flag.

A byte-wide register port gives software access to both flags, the two interrupt enables, the pulse-mode bit, the timer run bit, the source select and the count. Writing a zero to a flag bit clears that flag, and writing a one leaves it unchanged. The active-high interrupt output ORs the enabled timer term with the enabled alarm term. The timer term works in one of two ways. In level mode it follows the timer flag. In pulse mode it is a short window that opens in the same cycle as the flag, and its length depends on the source rate and on whether n equals one.

Top module: `rtc_timer_irq`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_o` is low.
- R2: The status byte at address 0 reads {000, pulse_mode[4], alarm_flag[3], timer_flag[2], alarm_en[1], timer_en[0]}. A write stores bits 4, 1 and 0 directly. Bits 7:5 always read 0.
- R3: Writing 0 to status bit 3 or bit 2 clears that flag. Writing 1 leaves the flag unchanged and never sets it.
- R4: If a hardware set of a flag and a write that clears it fall in the same cycle, the flag ends up set.
- R5: An `alarm_hit_i` pulse sets the alarm flag at the next clock edge.
- R6: With run set and n > 0, the first timer flag set comes n·D base ticks after the count write, where D is the source period in base ticks. Later expiries follow every n·D base ticks.
- R7: When n = 0 the timer never expires, even with run set.
- R8: In level mode (bit 4 = 0), `irq_o` is high whenever timer_flag and timer_en are both set, for as long as they stay set.
- R9: In pulse mode, the timer term goes high in the first cycle that timer_flag reads 1. It stays high for W base ticks. On the fastest source W is D/2 when n = 1 and D when n > 1. On the second source W is half the second-source period when n = 1 and that full period otherwise. On the two slow sources W is the second-source period.
- R10: When alarm_flag and alarm_en are both set, `irq_o` stays high in either mode.
- R11: Address 1 reads {run[7], 00000, src[1:0]}, where src 0 is 4096 Hz, 1 is 64 Hz, 2 is 1 Hz and 3 is 1/60 Hz. Address 2 holds n. Address 3 reads 0. A write to address 1 or 2 restarts the prescaler and reloads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| base_tick_i | input | 1 | 32768 Hz clock-enable |
| alarm_hit_i | input | 1 | Alarm match strobe, one cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Active-high interrupt |

## Verification
A timer expiry and a software write that clears the timer flag can fall in the same cycle. So can an alarm strobe and a write that clears the alarm flag. The bench runs the timer at its fastest source with n = 1 so that expiry falls on a known edge. It places a clearing write on exactly that edge and on a nearby edge that carries no expiry. The flag must survive the colliding write and must clear on the other. The alarm case is provoked by driving the strobe and the clearing write in the same cycle.

// File: rtl/rti_pkg.sv
package rti_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SRC_FAST = 2'd0,
        SRC_MID  = 2'd1,
        SRC_SEC  = 2'd2,
        SRC_MIN  = 2'd3
    } src_e;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_TCTL = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;

    typedef struct packed {
        logic [2:0] zero;
        logic       pulse_mode;
        logic       alarm_flag;
        logic       timer_flag;
        logic       alarm_en;
        logic       timer_en;
    } stat_t;

    typedef struct packed {
        logic       run;
        logic [4:0] zero;
        src_e       src;
    } tctl_t;

    // Interrupt window length in base ticks for a given source and count.
    function automatic int unsigned pulse_len(input src_e s, input logic n_one,
                                              input int unsigned div_fast,
                                              input int unsigned div_mid);
        int unsigned len;
        case (s)
            SRC_FAST: len = n_one ? div_fast / 2 : div_fast;
            SRC_MID:  len = n_one ? div_mid / 2 : div_mid;
            default:  len = div_mid;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rti_regfile.sv
module rti_regfile
    import rti_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              tf_set_i,
    input  logic              af_set_i,
    output logic [DATA_W-1:0] rdata_o,
    output stat_t             stat_o,
    output tctl_t             tctl_o,
    output logic [DATA_W-1:0] count_o,
    output logic              restart_o,
    output logic [DATA_W-1:0] load_val_o
);

    logic              pmode_q, af_q, tf_q, aie_q, tie_q, run_q;
    src_e              src_q;
    logic [DATA_W-1:0] count_q;
    logic              stat_wr, tctl_wr, cnt_wr;

    assign stat_wr = wr_en_i && (addr_i == ADDR_STAT);
    assign tctl_wr = wr_en_i && (addr_i == ADDR_TCTL);
    assign cnt_wr  = wr_en_i && (addr_i == ADDR_CNT);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pmode_q <= 1'b0;
            aie_q   <= 1'b0;
            tie_q   <= 1'b0;
        end else if (stat_wr) begin
            pmode_q <= wdata_i[4];
            aie_q   <= wdata_i[1];
            tie_q   <= wdata_i[0];
        end
    end

    // Sticky flags: a hardware set takes priority over a clearing write.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            af_q <= 1'b0;
            tf_q <= 1'b0;
        end else begin
            if (af_set_i)
                af_q <= 1'b1;
            else if (stat_wr && !wdata_i[3])
                af_q <= 1'b0;
            if (tf_set_i)
                tf_q <= 1'b1;
            else if (stat_wr && !wdata_i[2])
                tf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q   <= 1'b0;
            src_q   <= SRC_FAST;
            count_q <= '0;
        end else begin
            if (tctl_wr) begin
                run_q <= wdata_i[7];
                src_q <= src_e'(wdata_i[1:0]);
            end
            if (cnt_wr)
                count_q <= wdata_i;
        end
    end

    always_comb begin
        stat_o            = '0;
        stat_o.pulse_mode = pmode_q;
        stat_o.alarm_flag = af_q;
        stat_o.timer_flag = tf_q;
        stat_o.alarm_en   = aie_q;
        stat_o.timer_en   = tie_q;
        tctl_o            = '0;
        tctl_o.run        = run_q;
        tctl_o.src        = src_q;
    end

    assign count_o    = count_q;
    assign restart_o  = tctl_wr || cnt_wr;
    assign load_val_o = cnt_wr ? wdata_i : count_q;

    always_comb begin
        case (addr_i)
            ADDR_STAT: rdata_o = stat_o;
            ADDR_TCTL: rdata_o = tctl_o;
            ADDR_CNT:  rdata_o = count_q;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/rti_prescaler.sv
module rti_prescaler
    import rti_pkg::*;
#(
    parameter int DIV_FAST = 8,
    parameter int DIV_MID  = 512,
    parameter int DIV_SLOW = 32768,
    parameter int MIN_MULT = 60
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic base_tick_i,
    input  logic run_i,
    input  logic restart_i,
    input  src_e src_i,
    output logic tick_o
);

    localparam int PW = $clog2(DIV_SLOW);
    localparam int MW = (MIN_MULT > 1) ? $clog2(MIN_MULT) : 1;
    localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);
    localparam logic [PW-1:0] LIM_MID  = PW'(DIV_MID - 1);
    localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
    localparam logic [MW-1:0] LIM_MIN  = MW'(MIN_MULT - 1);

    logic [PW-1:0] div_q, lim;
    logic [MW-1:0] min_q;
    logic          step, wrap, min_done;

    always_comb begin
        case (src_i)
            SRC_FAST: lim = LIM_FAST;
            SRC_MID:  lim = LIM_MID;
            default:  lim = LIM_SLOW;
        endcase
    end

    assign step     = base_tick_i && run_i;
    assign wrap     = step && (div_q == lim);
    assign min_done = (src_i != SRC_MIN) || (min_q == LIM_MIN);
    assign tick_o   = wrap && min_done;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            div_q <= '0;
            min_q <= '0;
        end else if (step) begin
            if (div_q == lim) begin
                div_q <= '0;
                if (src_i == SRC_MIN)
                    min_q <= (min_q == LIM_MIN) ? '0 : min_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rti_countdown.sv
module rti_countdown
    import rti_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              restart_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic [DATA_W-1:0] reload_i,
    input  logic              tick_i,
    output logic              expire_o
);

    logic [DATA_W-1:0] cur_q;
    logic              last;

    assign last     = (cur_q <= DATA_W'(1));
    assign expire_o = tick_i && last;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cur_q <= '0;
        else if (restart_i)
            cur_q <= load_val_i;
        else if (tick_i)
            cur_q <= last ? reload_i : cur_q - 1'b1;
    end

endmodule

// File: rtl/rti_pulse.sv
module rti_pulse
    import rti_pkg::*;
#(
    parameter int DIV_FAST = 8,
    parameter int DIV_MID  = 512
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic base_tick_i,
    input  logic fire_i,
    input  src_e src_i,
    input  logic n_one_i,
    output logic active_o
);

    localparam int LW = $clog2(DIV_MID + 1);

    logic [LW-1:0] len, left_q;

    assign len      = LW'(pulse_len(src_i, n_one_i, DIV_FAST, DIV_MID));
    assign active_o = (left_q != '0);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            left_q <= '0;
        else if (fire_i)
            left_q <= len;
        else if (base_tick_i && active_o)
            left_q <= left_q - 1'b1;
    end

endmodule

// File: rtl/rtc_timer_irq.sv
module rtc_timer_irq
    import rti_pkg::*;
#(
    parameter int DIV_FAST = 8,
    parameter int DIV_MID  = 512,
    parameter int DIV_SLOW = 32768,
    parameter int MIN_MULT = 60
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       base_tick_i,
    input  logic       alarm_hit_i,
    input  logic       wr_en_i,
    input  logic [1:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       irq_o
);

    stat_t             stat;
    tctl_t             tctl;
    logic [DATA_W-1:0] count, load_val;
    logic              restart, src_tick, expire, pulse_act, run;
    logic              timer_term, alarm_term;

    rti_regfile u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .tf_set_i   (expire),
        .af_set_i   (alarm_hit_i),
        .rdata_o    (rdata_o),
        .stat_o     (stat),
        .tctl_o     (tctl),
        .count_o    (count),
        .restart_o  (restart),
        .load_val_o (load_val)
    );

    assign run = tctl.run && (count != '0);

    rti_prescaler #(
        .DIV_FAST (DIV_FAST),
        .DIV_MID  (DIV_MID),
        .DIV_SLOW (DIV_SLOW),
        .MIN_MULT (MIN_MULT)
    ) u_presc (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .base_tick_i (base_tick_i),
        .run_i       (run),
        .restart_i   (restart),
        .src_i       (tctl.src),
        .tick_o      (src_tick)
    );

    rti_countdown u_cnt (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .restart_i  (restart),
        .load_val_i (load_val),
        .reload_i   (count),
        .tick_i     (src_tick),
        .expire_o   (expire)
    );

    rti_pulse #(
        .DIV_FAST (DIV_FAST),
        .DIV_MID  (DIV_MID)
    ) u_pulse (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .base_tick_i (base_tick_i),
        .fire_i      (expire),
        .src_i       (tctl.src),
        .n_one_i     (count == DATA_W'(1)),
        .active_o    (pulse_act)
    );

    assign timer_term = stat.timer_flag && stat.timer_en &&
                        (!stat.pulse_mode || pulse_act);
    assign alarm_term = stat.alarm_flag && stat.alarm_en;
    assign irq_o      = timer_term || alarm_term;

endmodule

// File: rtl/rtc_timer_irq_chk.sv
module rtc_timer_irq_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       irq_o,
    input logic       alarm_hit_i,
    input logic       wr_en_i,
    input logic [1:0] addr_i,
    input logic [7:0] wdata_i,
    input logic [7:0] stat_bits,
    input logic       expire,
    input logic       pulse_act,
    input logic [7:0] count
);

    logic stat_wr;
    assign stat_wr = wr_en_i && (addr_i == 2'd0);

    assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !irq_o);

    assert_no_write_set_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (stat_wr && wdata_i[3] && !stat_bits[3] && !alarm_hit_i) |=> !stat_bits[3]);

    assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (expire && stat_wr && !wdata_i[2]) |=> stat_bits[2]);

    assert_alarm_sets_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        alarm_hit_i |=> stat_bits[3]);

    assert_zero_count_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (count == 8'd0) |-> !expire);

    assert_level_mode_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stat_bits[4] && stat_bits[2] && stat_bits[0]) |-> irq_o);

    assert_pulse_with_flag_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pulse_act) |-> stat_bits[2]);

    assert_alarm_holds_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (stat_bits[3] && stat_bits[1]) |-> irq_o);

endmodule

bind rtc_timer_irq rtc_timer_irq_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .irq_o       (irq_o),
    .alarm_hit_i (alarm_hit_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .stat_bits   (stat),
    .expire      (expire),
    .pulse_act   (pulse_act),
    .count       (count)
);

// File: tb/tb_rtc_timer_irq.sv
module tb_rtc_timer_irq;

    localparam int DF = 4;
    localparam int DM = 16;
    localparam int DS = 32;
    localparam int MM = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       alarm = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;
    int         total = 0;
    int         bad = 0;

    always #2 clk = ~clk;

    rtc_timer_irq #(
        .DIV_FAST (DF),
        .DIV_MID  (DM),
        .DIV_SLOW (DS),
        .MIN_MULT (MM)
    ) dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .base_tick_i (tick),
        .alarm_hit_i (alarm),
        .wr_en_i     (wr),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic int src_period(input int s);
        case (s)
            0: return DF;
            1: return DM;
            2: return DS;
            default: return DS * MM;
        endcase
    endfunction

    function automatic int exp_width(input int s, input int n);
        if (s == 0) return (n == 1) ? DF / 2 : DF;
        if (s == 1 && n == 1) return DM / 2;
        return DM;
    endfunction

    task automatic sweep_one(input logic [1:0] s, input int n);
        int e1 = -1;
        int e2 = -1;
        int w = 0;
        int tf_at = 0;
        int per;
        logic prev = 1'b0;
        logic [7:0] d;
        per = n * src_period(int'(s));
        wreg(2'd2, 8'h00);
        wreg(2'd0, 8'h00);
        wreg(2'd1, {1'b1, 5'b0, s});
        wreg(2'd0, 8'h11);
        wreg(2'd2, 8'(n));
        for (int e = 1; e <= 3 * per + 4 && e2 < 0; e++) begin
            @(negedge clk);
            rd(2'd0, d);
            if (irq && !prev) begin
                if (e1 < 0) begin
                    e1 = e;
                    tf_at = int'(d[2]);
                end else begin
                    e2 = e;
                end
            end
            if (irq && e1 >= 0 && e2 < 0) w++;
            prev = irq;
        end
        check($sformatf("R6 R11 first expiry src=%0d n=%0d", s, n), e1, per);
        check($sformatf("R9 flag with pulse src=%0d n=%0d", s, n), tf_at, 1);
        check($sformatf("R9 pulse width src=%0d n=%0d", s, n), w, exp_width(int'(s), n));
        check($sformatf("R6 reload period src=%0d n=%0d", s, n), e2 - e1, per);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check($sformatf("R1 reset value addr=%0d", a), d, 0);
        end
        check("R1 irq after reset", irq, 0);

        // R2 status layout, reserved bits
        wreg(2'd0, 8'hFF);
        rd(2'd0, d);
        check("R2 status writable bits", d, 8'h13);

        // R11 timer control and count
        wreg(2'd1, 8'hFF);
        rd(2'd1, d);
        check("R11 timer control readback", d, 8'h83);
        wreg(2'd2, 8'hA5);
        rd(2'd2, d);
        check("R11 count readback", d, 8'hA5);
        rd(2'd3, d);
        check("R11 unused address", d, 0);
        wreg(2'd2, 8'h00);
        wreg(2'd1, 8'h00);

        // R5 alarm set, R10 alarm holds irq in pulse mode
        @(negedge clk); alarm = 1'b1;
        @(negedge clk); alarm = 1'b0;
        rd(2'd0, d);
        check("R5 alarm flag set", d, 8'h1B);
        check("R10 irq with alarm", irq, 1);
        repeat (40) @(negedge clk);
        check("R10 irq still held", irq, 1);

        // R3 write 1 keeps, write 0 clears
        wreg(2'd0, 8'hFF);
        rd(2'd0, d);
        check("R3 write one keeps flag", d, 8'h1B);
        wreg(2'd0, 8'h17);
        rd(2'd0, d);
        check("R3 write zero clears flag", d, 8'h13);
        check("R3 irq after clear", irq, 0);

        // R7 zero count never expires
        wreg(2'd0, 8'h01);
        wreg(2'd1, 8'h80);
        wreg(2'd2, 8'h00);
        repeat (100) @(negedge clk);
        rd(2'd0, d);
        check("R7 no flag with n=0", d[2], 0);
        check("R7 irq with n=0", irq, 0);

        // R8 level mode: src 0, n=2, expiry after 8 edges
        wreg(2'd2, 8'h02);
        repeat (7) @(negedge clk);
        check("R8 irq before expiry", irq, 0);
        @(negedge clk);
        check("R8 irq at expiry", irq, 1);
        repeat (10) @(negedge clk);
        check("R8 level irq persists", irq, 1);

        // R4 collision of expiry with clearing write (src 0, n=1)
        wreg(2'd2, 8'h00);
        wreg(2'd0, 8'h00);
        wreg(2'd1, 8'h80);
        wreg(2'd2, 8'h01);
        repeat (4) @(negedge clk);
        rd(2'd0, d);
        check("R6 flag at n*D", d[2], 1);
        wr = 1'b1; addr = 2'd0; wdata = 8'h00;
        @(negedge clk);
        wr = 1'b0;
        rd(2'd0, d);
        check("R3 clear without collision", d[2], 0);
        repeat (2) @(negedge clk);
        wr = 1'b1; addr = 2'd0; wdata = 8'h00;
        @(negedge clk);
        wr = 1'b0;
        rd(2'd0, d);
        check("R4 timer set beats clear", d[2], 1);

        // R4 alarm strobe with clearing write
        wreg(2'd2, 8'h00);
        @(negedge clk);
        wr = 1'b1; addr = 2'd0; wdata = 8'h00; alarm = 1'b1;
        @(negedge clk);
        wr = 1'b0; alarm = 1'b0;
        rd(2'd0, d);
        check("R4 alarm set beats clear", d[3], 1);

        // R6 R9 R11 sweep over all sources and small counts
        for (int s = 0; s < 4; s++) begin
            for (int n = 1; n <= 3; n++) begin
                sweep_one(2'(s), n);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule